// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block takes a word in one fixed-point format and produces the same quantity in another. A format has three parts: a sign-bit count S (0 or 1), an integer-bit count I and a fractional-bit count F. The word is S+I+F bits wide and stands for the integer value of the word times 2^-F, read as two's complement when S is 1. Either count, I or F, may be negative, in the input format and in the output format alike.

When the output has fewer fractional bits than the input, one of seven rounding rules is applied. Six of them differ only in how an exact half is broken. When the rounded value does not fit the output range, one of four overflow policies is applied. Each policy either wraps or clamps, and either raises a warning flag or stays silent. The formats, the rounding rule, the overflow policy and an optional output register are all fixed at elaboration. A valid bit travels with the data, and the warning is aligned with the word it describes.

Top module: `fxcvt`

## Requirements
- R1: The input word is read as integer times 2^-IN_F, signed when IN_S=1. For example, [0,11,5] word 0xFCE3 (2023.09375) converts to 2023 in [0,11,0] under round-half-up.
- R2: When the output has more fractional bits, zero LSBs are appended. When it has more integer bits, signed inputs are sign-extended and unsigned inputs are zero-extended. For example, [0,3,0] word 7 becomes 14 in [1,5,1].
- R3: RND_MODE=0 (truncate) gives floor(x). For example, 2.75 gives 2 and -1.5 gives -2 in [1,2,0].
- R4: RND_MODE=1 (round half up) gives floor(x+0.5). For example, -1.5 gives -1 and 0.5 gives 1.
- R5: The remaining rounding modes differ from mode 1 only on exact ties. Mode 2 breaks ties toward minus infinity, mode 3 away from zero, mode 4 toward zero, mode 5 to even and mode 6 to odd.
- R6: SAT_MODE=0 keeps the low output bits of an out-of-range value, so the value wraps, and never raises outWarn.
- R7: SAT_MODE=1 wraps in the same way as mode 0 and raises outWarn for any out-of-range value.
- R8: SAT_MODE=2 clamps to the largest or smallest output value, with a negative input to an unsigned output giving 0. It never raises outWarn.
- R9: SAT_MODE=3 clamps as mode 2 does and raises outWarn for any out-of-range value.
- R10: Rounding is done with headroom, so a value that rounds up past the output maximum is treated as an overflow. For example, 3.5 to [1,2,0] gives 3 with a warning under clamp-and-warn.
- R11: Negative I or negative F is handled in either format. Examples: [1,4,-2] word -2 (-8) gives -16 in [1,6,1], and [1,6,0] value -10 gives word -2 in [1,4,-2] under round-half-up.
- R12: With REG_OUT=1, outWord, outValid and outWarn appear one clock after the input. With REG_OUT=0 they follow the input in the same cycle. outWarn is never high while outValid is low.
- R13: While rst_n is low, the registered outValid and outWarn are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks inWord as meaningful |
| inWord | input | IN_S+IN_I+IN_F | Value in the input format |
| outValid | output | 1 | Marks outWord as meaningful |
| outWord | output | OUT_S+OUT_I+OUT_F | Value in the output format |
| outWarn | output | 1 | Out-of-range indication, produced only in the warning policies |

## Verification
The checker watches every cycle for four things: a warning without valid, a warning in a silent policy, a clamp-and-warn word that is not at an extreme, and valid or warning out of step with the register latency. The numeric results cannot be checked that way and are shown only by the bench's scenarios. These are the seven tie rules over one shared table, wrap against clamp across the four policies, the headroom case at the top of the range, extension in both signed and unsigned cases, and formats with negative counts.

// File: rtl/fxcvt_pkg.sv
package fxcvt_pkg;

  typedef enum int {
    RND_TRUNC     = 0,
    RND_HALF_UP   = 1,
    RND_HALF_DOWN = 2,
    RND_HALF_AWAY = 3,
    RND_HALF_ZERO = 4,
    RND_HALF_EVEN = 5,
    RND_HALF_ODD  = 6
  } rnd_mode_e;

  typedef enum int {
    SAT_WRAP       = 0,
    SAT_WRAP_WARN  = 1,
    SAT_CLAMP      = 2,
    SAT_CLAMP_WARN = 3
  } sat_mode_e;

  // facts about the dropped fraction, produced by the alignment stage
  typedef struct packed {
    logic half;    // most significant dropped bit
    logic sticky;  // any dropped bit below it
    logic neg;     // input is negative
    logic lsb;     // lowest kept bit of the floor value
  } rnd_info_t;

  // strobes from control to the limiting stage
  typedef struct packed {
    logic roundUp;
    logic clampEn;
    logic warnEn;
  } strobe_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fxcvt_align.sv
module fxcvt_align
  import fxcvt_pkg::*;
#(
  parameter int IN_S = 1,
  parameter int IN_W = 8,
  parameter int UP   = 0,
  parameter int DN   = 0,
  parameter int WIDE = 12
) (
  input  logic [IN_W-1:0]        inWord,
  output logic signed [WIDE-1:0] floorVal,
  output rnd_info_t              info
);

  localparam int HALF_IDX = (DN > 0) ? DN - 1 : 0;
  localparam logic [WIDE-1:0] REST_MASK = (WIDE'(1) << HALF_IDX) - WIDE'(1);

  logic signed [WIDE-1:0] extVal;
  logic signed [WIDE-1:0] scaled;

  generate
    if (IN_S != 0) begin : g_sext
      assign extVal = {{(WIDE-IN_W){inWord[IN_W-1]}}, inWord};
    end else begin : g_zext
      assign extVal = {{(WIDE-IN_W){1'b0}}, inWord};
    end
  endgenerate

  always_comb begin
    scaled      = extVal <<< UP;
    floorVal    = scaled >>> DN;
    info.half   = (DN > 0) ? scaled[HALF_IDX] : 1'b0;
    info.sticky = |(scaled & REST_MASK);
    info.neg    = scaled[WIDE-1];
    info.lsb    = floorVal[0];
  end

endmodule

// File: rtl/fxcvt_ctrl.sv
module fxcvt_ctrl
  import fxcvt_pkg::*;
#(
  parameter rnd_mode_e RND_MODE = RND_HALF_UP,
  parameter sat_mode_e SAT_MODE = SAT_CLAMP_WARN
) (
  input  rnd_info_t info,
  output strobe_t   strb
);

  logic tie;
  logic above;

  always_comb begin
    tie   = info.half & ~info.sticky;
    above = info.half &  info.sticky;
    unique case (RND_MODE)
      RND_TRUNC:     strb.roundUp = 1'b0;
      RND_HALF_UP:   strb.roundUp = info.half;
      RND_HALF_DOWN: strb.roundUp = above;
      RND_HALF_AWAY: strb.roundUp = above | (tie & ~info.neg);
      RND_HALF_ZERO: strb.roundUp = above | (tie &  info.neg);
      RND_HALF_EVEN: strb.roundUp = above | (tie &  info.lsb);
      RND_HALF_ODD:  strb.roundUp = above | (tie & ~info.lsb);
      default:       strb.roundUp = 1'b0;
    endcase
    strb.clampEn = (SAT_MODE == SAT_CLAMP) || (SAT_MODE == SAT_CLAMP_WARN);
    strb.warnEn  = (SAT_MODE == SAT_WRAP_WARN) || (SAT_MODE == SAT_CLAMP_WARN);
  end

endmodule

// File: rtl/fxcvt_limit.sv
module fxcvt_limit
  import fxcvt_pkg::*;
#(
  parameter int OUT_S = 1,
  parameter int OUT_W = 8,
  parameter int WIDE  = 12
) (
  input  logic signed [WIDE-1:0] floorVal,
  input  strobe_t                strb,
  input  logic                   valid,
  output logic [OUT_W-1:0]       word,
  output logic                   warn
);

  localparam logic signed [WIDE-1:0] MAXV = (OUT_S != 0) ?
    $signed((WIDE'(1) << (OUT_W-1)) - WIDE'(1)) :
    $signed((WIDE'(1) << OUT_W) - WIDE'(1));
  localparam logic signed [WIDE-1:0] MINV = (OUT_S != 0) ?
    -$signed(WIDE'(1) << (OUT_W-1)) : '0;
  localparam logic [OUT_W-1:0] MAX_W = MAXV[OUT_W-1:0];
  localparam logic [OUT_W-1:0] MIN_W = MINV[OUT_W-1:0];

  logic signed [WIDE-1:0] rounded;
  logic overHi;
  logic underLo;

  always_comb begin
    rounded = floorVal + $signed({{(WIDE-1){1'b0}}, strb.roundUp});
    overHi  = rounded > MAXV;
    underLo = rounded < MINV;
    if (strb.clampEn && overHi)       word = MAX_W;
    else if (strb.clampEn && underLo) word = MIN_W;
    else                              word = rounded[OUT_W-1:0];
    warn = valid & strb.warnEn & (overHi | underLo);
  end

endmodule

// File: rtl/fxcvt.sv
module fxcvt
  import fxcvt_pkg::*;
#(
  parameter int        IN_S     = 1,
  parameter int        IN_I     = 6,
  parameter int        IN_F     = 0,
  parameter int        OUT_S    = 1,
  parameter int        OUT_I    = 4,
  parameter int        OUT_F    = -2,
  parameter rnd_mode_e RND_MODE = RND_HALF_UP,
  parameter sat_mode_e SAT_MODE = SAT_CLAMP_WARN,
  parameter bit        REG_OUT  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inValid,
  input  logic [IN_S+IN_I+IN_F-1:0]    inWord,
  output logic                         outValid,
  output logic [OUT_S+OUT_I+OUT_F-1:0] outWord,
  output logic                         outWarn
);

  localparam int IN_W  = IN_S + IN_I + IN_F;
  localparam int OUT_W = OUT_S + OUT_I + OUT_F;
  localparam int UP    = imax(0, OUT_F - IN_F);
  localparam int DN    = imax(0, IN_F - OUT_F);
  localparam int WIDE  = imax(imax(IN_W + UP, OUT_W), DN) + 2;

  logic signed [WIDE-1:0] floorVal;
  rnd_info_t              info;
  strobe_t                strb;
  logic [OUT_W-1:0]       combWord;
  logic                   combWarn;

  fxcvt_align #(.IN_S(IN_S), .IN_W(IN_W), .UP(UP), .DN(DN), .WIDE(WIDE)) u_align (
    .inWord(inWord), .floorVal(floorVal), .info(info));

  fxcvt_ctrl #(.RND_MODE(RND_MODE), .SAT_MODE(SAT_MODE)) u_ctrl (
    .info(info), .strb(strb));

  fxcvt_limit #(.OUT_S(OUT_S), .OUT_W(OUT_W), .WIDE(WIDE)) u_limit (
    .floorVal(floorVal), .strb(strb), .valid(inValid),
    .word(combWord), .warn(combWarn));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          outValid <= 1'b0;
          outWarn  <= 1'b0;
          outWord  <= '0;
        end else begin
          outValid <= inValid;
          outWarn  <= combWarn;
          outWord  <= combWord;
        end
      end
    end else begin : g_comb
      assign outValid = inValid;
      assign outWarn  = combWarn;
      assign outWord  = combWord;
    end
  endgenerate

endmodule

// File: rtl/fxcvt_chk.sv
module fxcvt_chk
  import fxcvt_pkg::*;
#(
  parameter int        OUT_W    = 8,
  parameter int        OUT_S    = 1,
  parameter sat_mode_e SAT_MODE = SAT_CLAMP_WARN,
  parameter bit        REG_OUT  = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outWord,
  input logic             outWarn
);

  localparam logic [OUT_W-1:0] HI_PAT = (OUT_S != 0) ? ({OUT_W{1'b1}} >> 1) : {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] LO_PAT = (OUT_S != 0) ? ~HI_PAT : '0;
  localparam bit QUIET = (SAT_MODE == SAT_WRAP) || (SAT_MODE == SAT_CLAMP);
  localparam bit CLAMP_WARN = (SAT_MODE == SAT_CLAMP_WARN);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_WARN_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    outWarn |-> outValid); // R12

  AST_QUIET_NO_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    QUIET |-> !outWarn); // R6

  AST_CLAMP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (CLAMP_WARN && outWarn) |-> (outWord == HI_PAT || outWord == LO_PAT)); // R9

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && armed) |-> (outValid == $past(inValid))); // R12

  AST_WARN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && armed && outWarn) |-> $past(inValid)); // R12

  AST_RESET_QUIET: assert property (@(posedge clk)
    (REG_OUT && !rst_n) |=> (!rst_n) |-> (!outValid && !outWarn)); // R13

endmodule

bind fxcvt fxcvt_chk #(
  .OUT_W(OUT_S + OUT_I + OUT_F), .OUT_S(OUT_S), .SAT_MODE(SAT_MODE), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid),
  .outValid(outValid), .outWord(outWord), .outWarn(outWarn)
);

// File: tb/tb_fxcvt.sv
module tb_fxcvt;
  import fxcvt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // registered main instance: [1,6,0] -> [1,4,-2], half up, clamp+warn
  logic       inValid = 1'b0;
  logic [6:0] inWord  = '0;
  logic       outValid, outWarn;
  logic [2:0] outWord;
  fxcvt #(.IN_S(1), .IN_I(6), .IN_F(0), .OUT_S(1), .OUT_I(4), .OUT_F(-2),
          .RND_MODE(RND_HALF_UP), .SAT_MODE(SAT_CLAMP_WARN), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outWord(outWord), .outWarn(outWarn));

  // rounding set: [1,3,2] -> [1,2,0], clamp+warn, one instance per mode
  logic       rndVal = 1'b0;
  logic [5:0] rndIn  = '0;
  logic [2:0] rndOut [7];
  logic       rndWarn [7];
  logic       rndOv [7];
  for (genvar m = 0; m < 7; m++) begin : g_rnd
    fxcvt #(.IN_S(1), .IN_I(3), .IN_F(2), .OUT_S(1), .OUT_I(2), .OUT_F(0),
            .RND_MODE(rnd_mode_e'(m)), .SAT_MODE(SAT_CLAMP_WARN), .REG_OUT(1'b0)) u (
      .clk(clk), .rst_n(rst_n), .inValid(rndVal), .inWord(rndIn),
      .outValid(rndOv[m]), .outWord(rndOut[m]), .outWarn(rndWarn[m]));
  end

  // overflow set: [1,4,0] -> [0,2,0], truncate, one instance per policy
  logic       satVal = 1'b0;
  logic [4:0] satIn  = '0;
  logic [1:0] satOut [4];
  logic       satWarn [4];
  logic       satOv [4];
  for (genvar s = 0; s < 4; s++) begin : g_sat
    fxcvt #(.IN_S(1), .IN_I(4), .IN_F(0), .OUT_S(0), .OUT_I(2), .OUT_F(0),
            .RND_MODE(RND_TRUNC), .SAT_MODE(sat_mode_e'(s)), .REG_OUT(1'b0)) u (
      .clk(clk), .rst_n(rst_n), .inValid(satVal), .inWord(satIn),
      .outValid(satOv[s]), .outWord(satOut[s]), .outWarn(satWarn[s]));
  end

  // [0,11,5] -> [0,11,0]
  logic [15:0] exIn = '0;
  logic [10:0] exOut;
  logic        exV, exW;
  fxcvt #(.IN_S(0), .IN_I(11), .IN_F(5), .OUT_S(0), .OUT_I(11), .OUT_F(0),
          .RND_MODE(RND_HALF_UP), .SAT_MODE(SAT_CLAMP_WARN), .REG_OUT(1'b0)) dutEx (
    .clk(clk), .rst_n(rst_n), .inValid(1'b1), .inWord(exIn),
    .outValid(exV), .outWord(exOut), .outWarn(exW));

  // [1,-2,4] -> [1,1,5]
  logic [2:0] negIn = '0;
  logic [6:0] negOut;
  logic       negV, negW;
  fxcvt #(.IN_S(1), .IN_I(-2), .IN_F(4), .OUT_S(1), .OUT_I(1), .OUT_F(5),
          .RND_MODE(RND_HALF_UP), .SAT_MODE(SAT_CLAMP_WARN), .REG_OUT(1'b0)) dutNeg (
    .clk(clk), .rst_n(rst_n), .inValid(1'b1), .inWord(negIn),
    .outValid(negV), .outWord(negOut), .outWarn(negW));

  // [1,4,-2] -> [1,6,1]
  logic [2:0] wideIn = '0;
  logic [7:0] wideOut;
  logic       wideV, wideW;
  fxcvt #(.IN_S(1), .IN_I(4), .IN_F(-2), .OUT_S(1), .OUT_I(6), .OUT_F(1),
          .RND_MODE(RND_TRUNC), .SAT_MODE(SAT_WRAP), .REG_OUT(1'b0)) dutWide (
    .clk(clk), .rst_n(rst_n), .inValid(1'b1), .inWord(wideIn),
    .outValid(wideV), .outWord(wideOut), .outWarn(wideW));

  // [0,3,0] -> [1,5,1]
  logic [2:0] unsIn = '0;
  logic [6:0] unsOut;
  logic       unsV, unsW;
  fxcvt #(.IN_S(0), .IN_I(3), .IN_F(0), .OUT_S(1), .OUT_I(5), .OUT_F(1),
          .RND_MODE(RND_TRUNC), .SAT_MODE(SAT_WRAP), .REG_OUT(1'b0)) dutUns (
    .clk(clk), .rst_n(rst_n), .inValid(1'b1), .inWord(unsIn),
    .outValid(unsV), .outWord(unsOut), .outWarn(unsW));

  // quarter-unit inputs: 2.25 2.75 -1.5 -0.5 0.5 1.5 3.5
  localparam int RIN [7] = '{9, 11, -6, -2, 2, 6, 14};
  // rounded value before range handling, row per rounding mode
  localparam int REXP [7][7] = '{
    '{2, 2, -2, -1, 0, 1, 3},
    '{2, 3, -1,  0, 1, 2, 4},
    '{2, 3, -2, -1, 0, 1, 3},
    '{2, 3, -2, -1, 1, 2, 4},
    '{2, 3, -1,  0, 0, 1, 3},
    '{2, 3, -2,  0, 0, 2, 4},
    '{2, 3, -1, -1, 1, 1, 3}};
  localparam int SIN  [5] = '{2, 5, -1, -16, 3};
  localparam int SWRAP[5] = '{2, 1, 3, 0, 3};
  localparam int SCLMP[5] = '{2, 3, 0, 0, 3};
  localparam int SOVER[5] = '{0, 1, 1, 1, 0};

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13", "outValid in reset", outValid, 0);
    chk("R13", "outWarn in reset", outWarn, 0);
    rst_n = 1'b1;

    // rounding table walk
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      rndIn = 6'(RIN[i]);
      rndVal = 1'b1;
      #1;
      for (int m = 0; m < 7; m++) begin
        int e;
        bit ov;
        string r;
        e = REXP[m][i];
        ov = (e > 3);
        if (ov) e = 3;
        r = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
        if (i == 6) r = "R10";
        chk(r, $sformatf("mode %0d input %0d", m, i), int'($signed(rndOut[m])), e);
        chk(ov ? "R10" : "R9", $sformatf("warn mode %0d input %0d", m, i), rndWarn[m], ov);
      end
    end
    rndVal = 1'b0;
    #1;
    chk("R12", "warn with valid low", rndWarn[1], 0);
    chk("R12", "valid follows input", rndOv[1], 0);

    // overflow policy walk
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      satIn = 5'(SIN[i]);
      satVal = 1'b1;
      #1;
      chk("R6", $sformatf("wrap input %0d", i), satOut[0], SWRAP[i]);
      chk("R6", $sformatf("wrap warn %0d", i), satWarn[0], 0);
      chk("R7", $sformatf("wrapwarn input %0d", i), satOut[1], SWRAP[i]);
      chk("R7", $sformatf("wrapwarn warn %0d", i), satWarn[1], SOVER[i]);
      chk("R8", $sformatf("clamp input %0d", i), satOut[2], SCLMP[i]);
      chk("R8", $sformatf("clamp warn %0d", i), satWarn[2], 0);
      chk("R9", $sformatf("clampwarn input %0d", i), satOut[3], SCLMP[i]);
      chk("R9", $sformatf("clampwarn warn %0d", i), satWarn[3], SOVER[i]);
    end
    satVal = 1'b0;

    // interpretation and extension
    @(negedge clk);
    exIn = 16'hFCE3; negIn = 3'b010; wideIn = 3'b110; unsIn = 3'd7;
    #1;
    chk("R1", "2023.09375 to integer", exOut, 2023);
    chk("R11", "0.125 from [1,-2,4]", int'($signed(negOut)), 4);
    chk("R11", "-8 from [1,4,-2]", int'($signed(wideOut)), -16);
    chk("R2", "unsigned zero-extend", int'($signed(unsOut)), 14);
    @(negedge clk);
    exIn = 16'h0010; negIn = 3'b100; wideIn = 3'b011;
    #1;
    chk("R1", "0.5 half up", exOut, 1);
    chk("R2", "-0.25 sign-extend", int'($signed(negOut)), -8);
    chk("R2", "12 from [1,4,-2]", int'($signed(wideOut)), 24);

    // registered instance: [1,6,0] -> [1,4,-2]
    begin
      int vin[4] = '{6, -10, 13, 14};
      int vex[4] = '{2, -2, 3, 3};
      int vwn[4] = '{0, 0, 0, 1};
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        inWord = 7'(vin[i]);
        inValid = 1'b1;
        #1;
        if (i == 0) chk("R12", "no output before edge", outValid, 0);
        @(negedge clk);
        chk("R11", $sformatf("registered value %0d", i), int'($signed(outWord)), vex[i]);
        chk("R12", $sformatf("registered valid %0d", i), outValid, 1);
        chk(vwn[i] != 0 ? "R10" : "R12", $sformatf("registered warn %0d", i), outWarn, vwn[i]);
        inValid = 1'b0;
      end
      @(negedge clk);
      chk("R12", "valid drops one cycle later", outValid, 0);
      chk("R12", "warn drops with valid", outWarn, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule